// File: doc/BRIEF.md
# Processor exception entry controller

This block records processor state when a general exception or a debug exception is raised. On a general exception it saves the faulting PC, the cause code and, when the exception carries one, the faulting virtual address. It then sets the exception-mode bit of the status register and picks one of three vectors. The vector is kernel, user or double. A double exception is one raised while exception mode is already set.

On a debug exception that the current interrupt level allows, the block does four things. It stores the debug cause. It saves the PC and a snapshot of the status register into the save slots of the configured debug level. It raises the interrupt level to that debug level and sets exception mode. Every accepted event produces a one-cycle taken pulse together with a two-bit vector ID. The pipeline around the block uses these to redirect fetch.

The core restores the status register through a load port, for example on return from an exception. Fetch redirection and interrupt arbitration stay outside this block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the status register (exception mode 0, user mode 0, interrupt level 0), every save register and the taken output.
- R2: A general exception raised while exception mode is clear stores the PC into the level-1 saved-PC register. When user mode is clear it selects vector ID 0 (kernel).
- R3: A general exception raised while exception mode is clear and user mode is set selects vector ID 1 (user). User mode keeps its value.
- R4: Every taken general exception writes the cause code into the cause register and sets exception mode. User mode and interrupt level are left unchanged.
- R5: A general exception raised while exception mode is set is a double exception and selects vector ID 2. With the double-PC register configured, the PC goes there and the level-1 saved-PC register keeps its value. Without it, the PC goes to the level-1 saved-PC register.
- R6: A general exception that carries an address writes it into the virtual-address register. Without the address flag, that register keeps its value.
- R7: A taken debug exception writes the debug cause, stores the PC into the debug-level saved-PC register, and copies the pre-entry status into the debug-level saved-status register. The saved-status layout is: bit 0 exception mode, bit 1 user mode, bits above these the interrupt level. It selects vector ID 3.
- R8: On debug entry the interrupt level becomes the configured debug level and exception mode is set. User mode keeps its value.
- R9: A debug request while the interrupt level is not below the debug level is ignored. No taken pulse is produced, and the debug cause, the debug save registers and the status stay unchanged.
- R10: When both requests arrive in the same cycle, an allowed debug request wins and the general request is dropped, so the cause register is unchanged. A blocked debug request lets the general request proceed.
- R11: A status load writes exception mode, user mode and interrupt level in the cycle after it is presented. It is ignored in a cycle in which an exception is taken.
- R12: Inputs are sampled on the rising edge. All register updates of one event and the taken pulse with its vector ID appear after that same edge and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_raise | input | 1 | General exception request |
| exc_cause | input | CAUSE_W | General exception cause code |
| exc_has_vaddr | input | 1 | Request carries a faulting address |
| exc_vaddr | input | PC_W | Faulting virtual address |
| dbg_raise | input | 1 | Debug exception request |
| dbg_cause | input | DCAUSE_W | Debug cause code |
| fault_pc | input | PC_W | PC of the faulting instruction |
| ps_load | input | 1 | Status register load strobe |
| ps_load_excm | input | 1 | Exception-mode value to load |
| ps_load_um | input | 1 | User-mode value to load |
| ps_load_intlevel | input | LVL_W | Interrupt-level value to load |
| taken | output | 1 | One-cycle pulse for an accepted event |
| vector_id | output | 2 | 0 kernel, 1 user, 2 double, 3 debug |
| ps_excm | output | 1 | Current exception-mode bit |
| ps_um | output | 1 | Current user-mode bit |
| ps_intlevel | output | LVL_W | Current interrupt level |
| epc_l1 | output | PC_W | Level-1 saved PC |
| depc | output | PC_W | Double-exception saved PC (0 when not configured) |
| exc_cause_reg | output | CAUSE_W | Cause register |
| exc_vaddr_reg | output | PC_W | Virtual-address register |
| dbg_cause_reg | output | DCAUSE_W | Debug-cause register |
| epc_dbg | output | PC_W | Saved PC at the debug level |
| eps_dbg | output | LVL_W+2 | Saved status at the debug level |

## Verification
The assertions check these properties on every cycle:
- every taken pulse follows a request;
- exception mode is set whenever a vector is issued;
- a double vector only follows a cycle with exception mode set;
- the debug vector always comes with the interrupt level at the debug level;
- a blocked debug request alone never yields a pulse;
- the virtual-address and debug-cause registers hold whenever no qualifying event occurs.

Only the bench scenarios can show stored values: the exact PC, cause and address in each save register, the status snapshot bit layout, the arbitration between simultaneous requests, and that a status load is dropped in an entry cycle.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   typedef enum logic [1:0] {
      VEC_KERNEL = 2'd0,
      VEC_USER   = 2'd1,
      VEC_DOUBLE = 2'd2,
      VEC_DEBUG  = 2'd3
   } vec_e;

   typedef enum logic [1:0] {
      EV_NONE    = 2'd0,
      EV_GENERAL = 2'd1,
      EV_DEBUG   = 2'd2
   } event_e;

endpackage

// File: rtl/exc_entry_decode.sv
module exc_entry_decode
   import exc_entry_pkg::*;
#(
   parameter int LVL_W     = 4,
   parameter int DBG_LEVEL = 6
) (
   input  logic             exc_raise,
   input  logic             dbg_raise,
   input  logic             cur_excm,
   input  logic             cur_um,
   input  logic [LVL_W-1:0] cur_intlevel,
   output event_e           ev,
   output vec_e             vec,
   output logic             dbl
);
   localparam logic [LVL_W-1:0] DBG_LVL_V = LVL_W'(DBG_LEVEL);

   logic dbg_ok;

   always_comb begin
      dbg_ok = dbg_raise && (cur_intlevel < DBG_LVL_V);
      dbl    = 1'b0;
      ev     = EV_NONE;
      vec    = VEC_KERNEL;
      if (dbg_ok) begin
         ev  = EV_DEBUG;
         vec = VEC_DEBUG;
      end else if (exc_raise) begin
         ev = EV_GENERAL;
         if (cur_excm) begin
            dbl = 1'b1;
            vec = VEC_DOUBLE;
         end else if (cur_um) begin
            vec = VEC_USER;
         end else begin
            vec = VEC_KERNEL;
         end
      end
   end

endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
   import exc_entry_pkg::*;
#(
   parameter int LVL_W     = 4,
   parameter int DBG_LEVEL = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  event_e           ev,
   input  logic             ld_en,
   input  logic             ld_excm,
   input  logic             ld_um,
   input  logic [LVL_W-1:0] ld_intlevel,
   output logic             excm,
   output logic             um,
   output logic [LVL_W-1:0] intlevel
);
   localparam logic [LVL_W-1:0] DBG_LVL_V = LVL_W'(DBG_LEVEL);

   always_ff @(posedge clk) begin
      if (rst) begin
         excm     <= 1'b0;
         um       <= 1'b0;
         intlevel <= '0;
      end else begin
         unique case (ev)
            EV_GENERAL: excm <= 1'b1;
            EV_DEBUG: begin
               excm     <= 1'b1;
               intlevel <= DBG_LVL_V;
            end
            default: begin
               if (ld_en) begin
                  excm     <= ld_excm;
                  um       <= ld_um;
                  intlevel <= ld_intlevel;
               end
            end
         endcase
      end
   end

   // R8: debug entry leaves the level at the debug level with exception mode set
   a_r8_debug_entry_level : assert property (@(posedge clk) disable iff (rst)
      (ev == EV_DEBUG) |=> (intlevel == DBG_LVL_V) && excm);

   // R11: a load is dropped in an entry cycle
   a_r11_load_ignored : assert property (@(posedge clk) disable iff (rst)
      (ev != EV_NONE) |=> excm);

endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank
   import exc_entry_pkg::*;
#(
   parameter int PC_W     = 32,
   parameter int CAUSE_W  = 6,
   parameter int DCAUSE_W = 6,
   parameter int PS_W     = 6,
   parameter bit HAS_DEPC = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  event_e              ev,
   input  logic                dbl,
   input  logic [PC_W-1:0]     pc,
   input  logic [CAUSE_W-1:0]  cause,
   input  logic                has_vaddr,
   input  logic [PC_W-1:0]     vaddr,
   input  logic [DCAUSE_W-1:0] dcause,
   input  logic [PS_W-1:0]     ps_snap,
   output logic [PC_W-1:0]     epc1,
   output logic [PC_W-1:0]     depc,
   output logic [CAUSE_W-1:0]  cause_q,
   output logic [PC_W-1:0]     vaddr_q,
   output logic [DCAUSE_W-1:0] dcause_q,
   output logic [PC_W-1:0]     epc_dbg,
   output logic [PS_W-1:0]     eps_dbg
);
   logic gen_ev, dbg_ev, pc_to_epc1;

   assign gen_ev = (ev == EV_GENERAL);
   assign dbg_ev = (ev == EV_DEBUG);

   generate
      if (HAS_DEPC) begin : g_depc
         logic [PC_W-1:0] depc_q;
         always_ff @(posedge clk) begin
            if (rst)                depc_q <= '0;
            else if (gen_ev && dbl) depc_q <= pc;
         end
         assign depc       = depc_q;
         assign pc_to_epc1 = gen_ev && !dbl;
      end else begin : g_no_depc
         assign depc       = '0;
         assign pc_to_epc1 = gen_ev;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         epc1     <= '0;
         cause_q  <= '0;
         vaddr_q  <= '0;
      end else begin
         if (pc_to_epc1)          epc1    <= pc;
         if (gen_ev)              cause_q <= cause;
         if (gen_ev && has_vaddr) vaddr_q <= vaddr;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dcause_q <= '0;
         epc_dbg  <= '0;
         eps_dbg  <= '0;
      end else if (dbg_ev) begin
         dcause_q <= dcause;
         epc_dbg  <= pc;
         eps_dbg  <= ps_snap;
      end
   end

   // R6: the address register holds without an address-carrying exception
   a_r6_vaddr_hold : assert property (@(posedge clk) disable iff (rst)
      !(gen_ev && has_vaddr) |=> $stable(vaddr_q));

   // R9: debug state holds when no debug entry is accepted
   a_r9_dbg_state_hold : assert property (@(posedge clk) disable iff (rst)
      !dbg_ev |=> $stable(dcause_q) && $stable(epc_dbg) && $stable(eps_dbg));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int CAUSE_W   = 6,
   parameter int DCAUSE_W  = 6,
   parameter int LVL_W     = 4,
   parameter int DBG_LEVEL = 6,
   parameter bit HAS_DEPC  = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                exc_raise,
   input  logic [CAUSE_W-1:0]  exc_cause,
   input  logic                exc_has_vaddr,
   input  logic [PC_W-1:0]     exc_vaddr,
   input  logic                dbg_raise,
   input  logic [DCAUSE_W-1:0] dbg_cause,
   input  logic [PC_W-1:0]     fault_pc,
   input  logic                ps_load,
   input  logic                ps_load_excm,
   input  logic                ps_load_um,
   input  logic [LVL_W-1:0]    ps_load_intlevel,
   output logic                taken,
   output logic [1:0]          vector_id,
   output logic                ps_excm,
   output logic                ps_um,
   output logic [LVL_W-1:0]    ps_intlevel,
   output logic [PC_W-1:0]     epc_l1,
   output logic [PC_W-1:0]     depc,
   output logic [CAUSE_W-1:0]  exc_cause_reg,
   output logic [PC_W-1:0]     exc_vaddr_reg,
   output logic [DCAUSE_W-1:0] dbg_cause_reg,
   output logic [PC_W-1:0]     epc_dbg,
   output logic [LVL_W+1:0]    eps_dbg
);
   localparam int PS_W = LVL_W + 2;

   generate
      if (DBG_LEVEL < 2 || DBG_LEVEL >= (1 << LVL_W)) begin : g_bad_level
         $error("DBG_LEVEL must be at least 2 and fit in LVL_W bits");
      end
      if (PC_W < 8 || CAUSE_W < 1 || DCAUSE_W < 1) begin : g_bad_width
         $error("field widths out of range");
      end
   endgenerate

   event_e          ev;
   vec_e            vec;
   logic            dbl;
   logic [PS_W-1:0] ps_snap;

   exc_entry_decode #(.LVL_W(LVL_W), .DBG_LEVEL(DBG_LEVEL)) u_dec (
      .exc_raise    (exc_raise),
      .dbg_raise    (dbg_raise),
      .cur_excm     (ps_excm),
      .cur_um       (ps_um),
      .cur_intlevel (ps_intlevel),
      .ev           (ev),
      .vec          (vec),
      .dbl          (dbl)
   );

   exc_status_reg #(.LVL_W(LVL_W), .DBG_LEVEL(DBG_LEVEL)) u_ps (
      .clk         (clk),
      .rst         (rst),
      .ev          (ev),
      .ld_en       (ps_load),
      .ld_excm     (ps_load_excm),
      .ld_um       (ps_load_um),
      .ld_intlevel (ps_load_intlevel),
      .excm        (ps_excm),
      .um          (ps_um),
      .intlevel    (ps_intlevel)
   );

   assign ps_snap = {ps_intlevel, ps_um, ps_excm};

   exc_save_bank #(
      .PC_W(PC_W), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W),
      .PS_W(PS_W), .HAS_DEPC(HAS_DEPC)
   ) u_save (
      .clk       (clk),
      .rst       (rst),
      .ev        (ev),
      .dbl       (dbl),
      .pc        (fault_pc),
      .cause     (exc_cause),
      .has_vaddr (exc_has_vaddr),
      .vaddr     (exc_vaddr),
      .dcause    (dbg_cause),
      .ps_snap   (ps_snap),
      .epc1      (epc_l1),
      .depc      (depc),
      .cause_q   (exc_cause_reg),
      .vaddr_q   (exc_vaddr_reg),
      .dcause_q  (dbg_cause_reg),
      .epc_dbg   (epc_dbg),
      .eps_dbg   (eps_dbg)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         taken     <= 1'b0;
         vector_id <= 2'd0;
      end else begin
         taken     <= (ev != EV_NONE);
         vector_id <= vec;
      end
   end

   // R12: a taken pulse always follows a request
   a_r12_taken_needs_req : assert property (@(posedge clk) disable iff (rst)
      taken |-> $past(exc_raise || dbg_raise));

   // R4: exception mode is set whenever a vector is issued
   a_r4_excm_on_entry : assert property (@(posedge clk) disable iff (rst)
      taken |-> ps_excm);

   // R5: the double vector only follows a cycle in exception mode
   a_r5_double_after_excm : assert property (@(posedge clk) disable iff (rst)
      (taken && vector_id == 2'd2) |-> $past(ps_excm));

   // R3: the user vector only follows a cycle in user mode outside exception mode
   a_r3_user_vector : assert property (@(posedge clk) disable iff (rst)
      (taken && vector_id == 2'd1) |-> $past(ps_um) && !$past(ps_excm));

   // R8: the debug vector comes with the level at the debug level
   a_r8_debug_vector_level : assert property (@(posedge clk) disable iff (rst)
      (taken && vector_id == 2'd3) |-> (ps_intlevel == LVL_W'(DBG_LEVEL)));

   // R9: a blocked debug request on its own yields no pulse
   a_r9_debug_blocked : assert property (@(posedge clk) disable iff (rst)
      (dbg_raise && !exc_raise && ps_intlevel >= LVL_W'(DBG_LEVEL)) |=> !taken);

endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
   localparam int PC_W = 32, CW = 6, DW = 6, LW = 4, DBGL = 6;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic exc_raise = 0, exc_has_vaddr = 0, dbg_raise = 0;
   logic ps_load = 0, ps_load_excm = 0, ps_load_um = 0;
   logic [LW-1:0]   ps_load_intlevel = '0;
   logic [CW-1:0]   exc_cause = '0;
   logic [DW-1:0]   dbg_cause = '0;
   logic [PC_W-1:0] exc_vaddr = '0, fault_pc = '0;
   logic taken, ps_excm, ps_um;
   logic [1:0] vector_id;
   logic [LW-1:0] ps_intlevel;
   logic [PC_W-1:0] epc_l1, depc, exc_vaddr_reg, epc_dbg;
   logic [CW-1:0] exc_cause_reg;
   logic [DW-1:0] dbg_cause_reg;
   logic [LW+1:0] eps_dbg;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   exc_entry_ctrl #(.PC_W(PC_W), .CAUSE_W(CW), .DCAUSE_W(DW),
                    .LVL_W(LW), .DBG_LEVEL(DBGL), .HAS_DEPC(1'b1)) uut (
      .clk(clk), .rst(rst),
      .exc_raise(exc_raise), .exc_cause(exc_cause),
      .exc_has_vaddr(exc_has_vaddr), .exc_vaddr(exc_vaddr),
      .dbg_raise(dbg_raise), .dbg_cause(dbg_cause), .fault_pc(fault_pc),
      .ps_load(ps_load), .ps_load_excm(ps_load_excm), .ps_load_um(ps_load_um),
      .ps_load_intlevel(ps_load_intlevel),
      .taken(taken), .vector_id(vector_id),
      .ps_excm(ps_excm), .ps_um(ps_um), .ps_intlevel(ps_intlevel),
      .epc_l1(epc_l1), .depc(depc), .exc_cause_reg(exc_cause_reg),
      .exc_vaddr_reg(exc_vaddr_reg), .dbg_cause_reg(dbg_cause_reg),
      .epc_dbg(epc_dbg), .eps_dbg(eps_dbg)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // Presents one cycle of stimulus, then returns at the next falling edge
   // where the results of that rising edge are visible.
   task automatic pulse(input logic g, input logic d, input logic ld);
      @(negedge clk);
      exc_raise = g; dbg_raise = d; ps_load = ld;
      @(negedge clk);
      exc_raise = 0; dbg_raise = 0; ps_load = 0; exc_has_vaddr = 0;
   endtask

   task automatic load_ps(input logic e, input logic u, input logic [LW-1:0] l);
      ps_load_excm = e; ps_load_um = u; ps_load_intlevel = l;
      pulse(0, 0, 1);
   endtask

   task automatic t_reset();
      chk("R1", "taken", taken, 0);
      chk("R1", "excm", ps_excm, 0);
      chk("R1", "um", ps_um, 0);
      chk("R1", "intlevel", ps_intlevel, 0);
      chk("R1", "epc1", epc_l1, 0);
      chk("R1", "eps_dbg", eps_dbg, 0);
   endtask

   task automatic t_kernel();
      fault_pc = 32'h0000_1000; exc_cause = 6'd5; exc_vaddr = 32'h1234_5678;
      exc_has_vaddr = 0;
      pulse(1, 0, 0);
      chk("R2", "taken", taken, 1);
      chk("R2", "vector", vector_id, 0);
      chk("R2", "epc1", epc_l1, 32'h1000);
      chk("R4", "cause", exc_cause_reg, 5);
      chk("R4", "excm", ps_excm, 1);
      chk("R6", "vaddr unchanged", exc_vaddr_reg, 0);
      @(negedge clk);
      chk("R12", "taken falls", taken, 0);
   endtask

   task automatic t_double();
      fault_pc = 32'h0000_2000; exc_cause = 6'd9;
      exc_has_vaddr = 1; exc_vaddr = 32'hDEAD_0000;
      pulse(1, 0, 0);
      chk("R5", "vector", vector_id, 2);
      chk("R5", "depc", depc, 32'h2000);
      chk("R5", "epc1 kept", epc_l1, 32'h1000);
      chk("R6", "vaddr", exc_vaddr_reg, 32'hDEAD_0000);
      chk("R4", "cause", exc_cause_reg, 9);
   endtask

   task automatic t_user();
      load_ps(0, 1, 4'd1);
      chk("R11", "load um", ps_um, 1);
      chk("R11", "load excm", ps_excm, 0);
      chk("R11", "load lvl", ps_intlevel, 1);
      fault_pc = 32'h0000_3000; exc_cause = 6'd12;
      pulse(1, 0, 0);
      chk("R3", "vector", vector_id, 1);
      chk("R3", "um kept", ps_um, 1);
      chk("R4", "lvl kept", ps_intlevel, 1);
      chk("R2", "epc1", epc_l1, 32'h3000);
   endtask

   task automatic t_load_during_entry();
      load_ps(0, 0, 4'd0);
      ps_load_excm = 0; ps_load_um = 1; ps_load_intlevel = 4'd3;
      fault_pc = 32'h0000_4000; exc_cause = 6'd2;
      pulse(1, 0, 1);
      chk("R11", "excm after ignored load", ps_excm, 1);
      chk("R11", "um after ignored load", ps_um, 0);
      chk("R11", "lvl after ignored load", ps_intlevel, 0);
   endtask

   task automatic t_debug();
      load_ps(0, 1, 4'd2);
      fault_pc = 32'h0000_5000; dbg_cause = 6'h11;
      pulse(0, 1, 0);
      chk("R7", "taken", taken, 1);
      chk("R7", "vector", vector_id, 3);
      chk("R7", "dcause", dbg_cause_reg, 6'h11);
      chk("R7", "epc_dbg", epc_dbg, 32'h5000);
      chk("R7", "eps_dbg", eps_dbg, 6'h0A);
      chk("R8", "lvl", ps_intlevel, DBGL);
      chk("R8", "excm", ps_excm, 1);
      chk("R8", "um", ps_um, 1);
      chk("R7", "cause untouched", exc_cause_reg, 2);
   endtask

   task automatic t_debug_blocked();
      load_ps(0, 0, 4'(DBGL));
      fault_pc = 32'h0000_6000; dbg_cause = 6'h22;
      pulse(0, 1, 0);
      chk("R9", "no taken", taken, 0);
      chk("R9", "dcause kept", dbg_cause_reg, 6'h11);
      chk("R9", "epc_dbg kept", epc_dbg, 32'h5000);
      chk("R9", "excm kept", ps_excm, 0);
      load_ps(0, 0, 4'd9);
      pulse(0, 1, 0);
      chk("R9", "above level no taken", taken, 0);
      chk("R9", "lvl kept", ps_intlevel, 9);
   endtask

   task automatic t_both();
      load_ps(0, 0, 4'd0);
      fault_pc = 32'h0000_7000; exc_cause = 6'd30; dbg_cause = 6'h05;
      pulse(1, 1, 0);
      chk("R10", "debug wins", vector_id, 3);
      chk("R10", "cause dropped", exc_cause_reg, 2);
      chk("R10", "dcause", dbg_cause_reg, 6'h05);
      load_ps(0, 0, 4'(DBGL));
      fault_pc = 32'h0000_8000; exc_cause = 6'd31;
      pulse(1, 1, 0);
      chk("R10", "general proceeds", taken, 1);
      chk("R10", "kernel vector", vector_id, 0);
      chk("R10", "cause", exc_cause_reg, 31);
      chk("R10", "epc1", epc_l1, 32'h8000);
      chk("R10", "dcause kept", dbg_cause_reg, 6'h05);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst = 0;
      t_kernel();
      t_double();
      t_user();
      t_load_during_entry();
      t_debug();
      t_debug_blocked();
      t_both();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule